// File: doc/BRIEF.md
# Two-Wire Slave Address Recognizer

This block is the byte engine of a two-wire serial bus slave. It receives already-conditioned bus events as single-cycle strobes: a START, a STOP, and a rising clock edge with the sampled data bit. It shifts bits MSB-first through one host-visible data register, and in transmit mode it drives the outgoing bit from the same register. As a result, the register always holds the last byte that appeared on the bus.

After each START, the first eight bits form the address byte. The upper seven bits are compared against a programmed own address, and optionally against the all-zero general call address. On a match, the block raises an interrupt flag, acknowledges the address on its own, and takes the direction from the byte's last bit. The block also raises the flag at the end of every data byte. While the flag is set, the block holds the bus clock low, ignores bus clock strobes, and freezes the data register against shifting. The host clears the flag by writing 1 to it, which lets the transfer continue.

Top module: `twi_addr_slave`

## Requirements
- R1: After reset, the address register reads 0xFE, the data register reads 0xFF, and `irq_o`, `scl_hold_o`, `sda_low_o` and `slave_tx_o` are all 0.
- R2: Host writes use `host_sel_i`. Code 0 selects the data register. Code 1 selects the address register, where bits 7:1 are the own address and bit 0 is the general call enable; this register is writable at any time. Code 2 selects control, where bit 0 is the flag clear.
- R3: On each `scl_rise_i` strobe that is taken, `sda_i` enters the data register at the LSB and the rest shifts toward the MSB. After a START, the first 8 taken bits form the address byte.
- R4: If the upper 7 bits of the address byte equal the own address, the flag and `irq_o` are set, `sda_low_o` is 1 during the acknowledge slot, and `slave_tx_o` takes bit 0 of the byte (1 means transmit).
- R5: An address byte whose upper 7 bits are zero matches only when address register bit 0 is 1.
- R6: A non-matching address byte sets no flag and drives no acknowledge. Further bit strobes are then ignored until the next START.
- R7: A host write to the data register changes it only while the flag is set. At any other time the write has no effect.
- R8: While the flag is set, `scl_rise_i` strobes are ignored and the data register keeps its value, except for host writes to it.
- R9: `scl_hold_o` equals the flag. Writing control bit 0 = 1 clears the flag. Writing 0 leaves the flag set.
- R10: In receive mode, the flag is set after the 8th data bit and the block drives an acknowledge (`sda_low_o` = 1) in the following slot.
- R11: In transmit mode, `sda_low_o` is the inverse of data register bit 7 during data bits. After the byte, the flag is set and SDA is released. A 1 sampled at the acknowledge clock (master NACK) returns the block to idle.
- R12: A STOP returns the block to idle without setting the flag. A START in the middle of a byte restarts address reception with a fresh bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START condition strobe |
| stop_i | input | 1 | STOP condition strobe |
| scl_rise_i | input | 1 | Bus clock rising-edge strobe |
| sda_i | input | 1 | Bus data bit, valid with scl_rise_i |
| host_wr_i | input | 1 | Host write strobe |
| host_sel_i | input | 2 | Host register select (0 data, 1 address, 2 control) |
| host_wdata_i | input | 8 | Host write data |
| data_o | output | 8 | Data register contents |
| addr_cfg_o | output | 8 | Address register contents |
| irq_o | output | 1 | Interrupt flag |
| scl_hold_o | output | 1 | Hold bus clock low (stretch) |
| sda_low_o | output | 1 | Pull bus data low |
| slave_tx_o | output | 1 | Slave-transmit direction latched from the address byte |

## Verification
The bench targets the following corner cases:
- **General call with the enable off:** a design that ignores the enable bit would acknowledge an all-zero address.
- **Strobes and data writes while the flag is set, and data writes while it is clear:** a design that ignores the freeze would corrupt the byte the host is reading, and a design that accepts writes at any time would let stray writes overwrite received data.
- **Transmit of a byte with mixed bits, then a master NACK:** this exposes inverted drive polarity, a missing release of SDA in the acknowledge slot, and a slave that keeps driving after the NACK.
- **STOP and a restarted START in the middle of a byte:** these reveal a bit counter that is not cleared, and a STOP that raises the flag.

// File: rtl/twi_slave_pkg.sv
package twi_slave_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_ACK  = 2'd3
  } seq_state_e;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
endpackage

// File: rtl/twi_data_shreg.sv
module twi_data_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         bit_i,
  input  logic         load_en_i,
  input  logic [W-1:0] load_data_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] next_o
);
  logic [W-1:0] data_q;

  // value after the pending shift; used by the comparator on the last bit
  assign next_o = {data_q[W-2:0], bit_i};
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         data_q <= '1;
    else if (load_en_i)  data_q <= load_data_i;
    else if (shift_en_i) data_q <= next_o;
  end
endmodule

// File: rtl/twi_addr_cmp.sv
module twi_addr_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] cfg_i,
  input  logic [W-1:0] byte_i,
  output logic         match_o
);
  localparam int AW = W - 1;

  logic own_hit, gc_hit;

  assign own_hit = (byte_i[W-1:1] == cfg_i[W-1:1]);
  assign gc_hit  = cfg_i[0] && (byte_i[W-1:1] == {AW{1'b0}});
  assign match_o = own_hit || gc_hit;
endmodule

// File: rtl/twi_bit_seq.sv
module twi_bit_seq
  import twi_slave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic scl_rise_i,
  input  logic sda_i,
  input  logic flag_clr_i,
  input  logic match_i,
  input  logic dir_bit_i,
  input  logic tx_msb_i,
  output logic shift_en_o,
  output logic flag_o,
  output logic tx_o,
  output logic sda_low_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  seq_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic flag_q, tx_q, ack_q, addr_slot_q;
  logic taken, byte_end, addr_hit, data_end;

  assign taken      = scl_rise_i && !flag_q && !start_i && !stop_i;
  assign shift_en_o = taken && (state_q == ST_ADDR || state_q == ST_DATA);
  assign byte_end   = shift_en_o && (cnt_q == LAST);
  assign addr_hit   = byte_end && (state_q == ST_ADDR) && match_i;
  assign data_end   = byte_end && (state_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      tx_q        <= 1'b0;
      ack_q       <= 1'b0;
      addr_slot_q <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      tx_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      tx_q    <= 1'b0;
    end else if (taken) begin
      unique case (state_q)
        ST_ADDR: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            if (match_i) begin
              state_q     <= ST_ACK;
              ack_q       <= 1'b1;
              tx_q        <= dir_bit_i;
              addr_slot_q <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == LAST) begin
            cnt_q       <= '0;
            state_q     <= ST_ACK;
            ack_q       <= !tx_q;
            addr_slot_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ACK: begin
          ack_q <= 1'b0;
          cnt_q <= '0;
          // master NACK after a transmitted data byte ends the transfer
          if (tx_q && !addr_slot_q && sda_i) begin
            state_q <= ST_IDLE;
            tx_q    <= 1'b0;
          end else begin
            state_q <= ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    flag_q <= 1'b0;
    else if (addr_hit || data_end)  flag_q <= 1'b1;
    else if (flag_clr_i)            flag_q <= 1'b0;
  end

  assign flag_o    = flag_q;
  assign tx_o      = tx_q;
  assign sda_low_o = (state_q == ST_ACK  && ack_q) ||
                     (state_q == ST_DATA && tx_q && !tx_msb_i);
endmodule

// File: rtl/twi_addr_slave.sv
module twi_addr_slave
  import twi_slave_pkg::*;
#(
  parameter int          W         = 8,
  parameter logic [W-1:0] ADDR_RST = 8'hFE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         scl_rise_i,
  input  logic         sda_i,
  input  logic         host_wr_i,
  input  logic [1:0]   host_sel_i,
  input  logic [W-1:0] host_wdata_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] addr_cfg_o,
  output logic         irq_o,
  output logic         scl_hold_o,
  output logic         sda_low_o,
  output logic         slave_tx_o
);
  logic [W-1:0] addr_q, data_next;
  logic shift_en, flag, match, data_wr, flag_clr;

  assign data_wr  = host_wr_i && (host_sel_i == SEL_DATA) && flag;
  assign flag_clr = host_wr_i && (host_sel_i == SEL_CTRL) && host_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        addr_q <= ADDR_RST;
    else if (host_wr_i && host_sel_i == SEL_ADDR)       addr_q <= host_wdata_i;
  end

  twi_data_shreg #(.W(W)) i_shreg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_en_i  (shift_en),
    .bit_i       (sda_i),
    .load_en_i   (data_wr),
    .load_data_i (host_wdata_i),
    .data_o      (data_o),
    .next_o      (data_next)
  );

  twi_addr_cmp #(.W(W)) i_cmp (
    .cfg_i   (addr_q),
    .byte_i  (data_next),
    .match_o (match)
  );

  twi_bit_seq #(.W(W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .scl_rise_i (scl_rise_i),
    .sda_i      (sda_i),
    .flag_clr_i (flag_clr),
    .match_i    (match),
    .dir_bit_i  (data_next[0]),
    .tx_msb_i   (data_o[W-1]),
    .shift_en_o (shift_en),
    .flag_o     (flag),
    .tx_o       (slave_tx_o),
    .sda_low_o  (sda_low_o)
  );

  assign addr_cfg_o = addr_q;
  assign irq_o      = flag;
  assign scl_hold_o = flag;
endmodule

// File: rtl/twi_addr_slave_chk.sv
module twi_addr_slave_chk
  import twi_slave_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         stop_i,
  input logic         scl_rise_i,
  input logic         host_wr_i,
  input logic [1:0]   host_sel_i,
  input logic [W-1:0] host_wdata_i,
  input logic [W-1:0] data_o,
  input logic         irq_o
);
  logic dwr, clr;
  assign dwr = host_wr_i && host_sel_i == SEL_DATA;
  assign clr = host_wr_i && host_sel_i == SEL_CTRL && host_wdata_i[0];

  assert_frozen_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !dwr |=> $stable(data_o));

  assert_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && dwr && !scl_rise_i |=> $stable(data_o));

  assert_stop_no_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !irq_o |=> !irq_o);

  assert_flag_on_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(scl_rise_i));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && clr |=> !irq_o);

  assert_fall_by_host_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(clr));
endmodule

bind twi_addr_slave twi_addr_slave_chk #(.W(W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stop_i       (stop_i),
  .scl_rise_i   (scl_rise_i),
  .host_wr_i    (host_wr_i),
  .host_sel_i   (host_sel_i),
  .host_wdata_i (host_wdata_i),
  .data_o       (data_o),
  .irq_o        (irq_o)
);

// File: tb/test_twi_addr_slave.sv
module test_twi_addr_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start, stop, scl_rise, sda, host_wr;
  logic [1:0] host_sel;
  logic [7:0] host_wdata, data, addr_cfg;
  logic irq, scl_hold, sda_low, slave_tx;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  twi_addr_slave i_twi_addr_slave (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .scl_rise_i(scl_rise), .sda_i(sda), .host_wr_i(host_wr),
    .host_sel_i(host_sel), .host_wdata_i(host_wdata), .data_o(data),
    .addr_cfg_o(addr_cfg), .irq_o(irq), .scl_hold_o(scl_hold),
    .sda_low_o(sda_low), .slave_tx_o(slave_tx)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic bus_bit(logic b);
    @(negedge clk) begin sda = b; scl_rise = 1'b1; end
    @(negedge clk) scl_rise = 1'b0;
  endtask

  task automatic bus_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
  endtask

  task automatic hwr(logic [1:0] sel, logic [7:0] v);
    @(negedge clk) begin host_wr = 1'b1; host_sel = sel; host_wdata = v; end
    @(negedge clk) host_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 addr", addr_cfg, 8'hFE);
    chk("R1 data", data, 8'hFF);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 hold", {7'd0, scl_hold}, 8'd0);
    chk("R1 sda_low", {7'd0, sda_low}, 8'd0);
    chk("R1 tx", {7'd0, slave_tx}, 8'd0);
  endtask

  task automatic t_rx_path();
    hwr(2'd1, 8'hB4);
    chk("R2 addr write", addr_cfg, 8'hB4);
    pulse_start();
    bus_byte(8'hB4);
    chk("R4 irq", {7'd0, irq}, 8'd1);
    chk("R4 ack", {7'd0, sda_low}, 8'd1);
    chk("R4 dir rx", {7'd0, slave_tx}, 8'd0);
    chk("R3 data holds addr byte", data, 8'hB4);
    chk("R9 hold", {7'd0, scl_hold}, 8'd1);
    bus_bit(1'b1);
    chk("R8 strobe ignored", data, 8'hB4);
    hwr(2'd0, 8'h33);
    chk("R7 write with flag", data, 8'h33);
    hwr(2'd2, 8'h01);
    chk("R9 clear", {7'd0, irq}, 8'd0);
    chk("R9 hold released", {7'd0, scl_hold}, 8'd0);
    bus_bit(1'b0);
    bus_byte(8'hC3);
    chk("R10 irq", {7'd0, irq}, 8'd1);
    chk("R10 data", data, 8'hC3);
    chk("R10 ack", {7'd0, sda_low}, 8'd1);
    hwr(2'd2, 8'h01);
    hwr(2'd0, 8'h11);
    chk("R7 write ignored", data, 8'hC3);
    bus_bit(1'b0);
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    chk("R3 partial shift", data, 8'h1D);
    pulse_stop();
    chk("R12 stop no flag", {7'd0, irq}, 8'd0);
    bus_bit(1'b1);
    chk("R12 idle after stop", data, 8'h1D);
  endtask

  task automatic t_restart();
    pulse_start();
    bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b1);
    pulse_start();
    bus_byte(8'hB4);
    chk("R12 restart match", {7'd0, irq}, 8'd1);
    chk("R12 restart data", data, 8'hB4);
    hwr(2'd2, 8'h01);
    pulse_stop();
  endtask

  task automatic t_mismatch();
    pulse_start();
    bus_byte(8'h44);
    chk("R6 no irq", {7'd0, irq}, 8'd0);
    chk("R6 no ack", {7'd0, sda_low}, 8'd0);
    chk("R6 data", data, 8'h44);
    bus_bit(1'b1);
    chk("R6 ignored bits", data, 8'h44);
  endtask

  task automatic t_gcall();
    pulse_start();
    bus_byte(8'h00);
    chk("R5 gc disabled", {7'd0, irq}, 8'd0);
    hwr(2'd1, 8'hB5);
    pulse_start();
    bus_byte(8'h01);
    chk("R5 gc enabled", {7'd0, irq}, 8'd1);
    chk("R5 gc ack", {7'd0, sda_low}, 8'd1);
    hwr(2'd2, 8'h01);
    pulse_stop();
  endtask

  task automatic t_tx_path();
    logic [7:0] v = 8'hA6;
    pulse_start();
    bus_byte(8'hB5);
    chk("R4 dir tx", {7'd0, slave_tx}, 8'd1);
    hwr(2'd0, v);
    hwr(2'd2, 8'h00);
    chk("R9 write 0 keeps flag", {7'd0, irq}, 8'd1);
    hwr(2'd2, 8'h01);
    chk("R4 ack held after clear", {7'd0, sda_low}, 8'd1);
    bus_bit(1'b0);
    for (int i = 7; i >= 0; i--) begin
      chk("R11 drive bit", {7'd0, sda_low}, {7'd0, ~v[i]});
      bus_bit(v[i]);
    end
    chk("R11 irq", {7'd0, irq}, 8'd1);
    chk("R11 released", {7'd0, sda_low}, 8'd0);
    chk("R11 data", data, v);
    hwr(2'd2, 8'h01);
    bus_bit(1'b1);
    bus_bit(1'b0);
    chk("R11 idle after nack", data, v);
    chk("R11 no drive after nack", {7'd0, sda_low}, 8'd0);
  endtask

  initial begin
    start = 0; stop = 0; scl_rise = 0; sda = 1; host_wr = 0;
    host_sel = 0; host_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_path();
    t_restart();
    t_mismatch();
    t_gcall();
    t_tx_path();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule